// File: doc/BRIEF.md
# Trigger Latency Hit Buffer

This block terminates one pixel column. Each incoming hit carries a row address and two Gray-coded edge stamps: the time the pulse crossed threshold and the time it fell back. The block decodes both stamps and stores the row with the leading-edge time and a 5-bit time-over-threshold (ToT) charge value. The entry then goes into one of a small set of slots and waits there for a trigger decision.

A trigger pulse selects one bunch crossing, namely the one that lies exactly a fixed latency before the current timestamp. Only entries whose leading-edge time equals that crossing are kept for readout. An entry that is never selected is released once it is older than the latency, so most hits leave the block silently. Selected entries are streamed out as row and ToT words under valid/ready flow control, oldest first. When no slot is free, the input is refused and each refused cycle is counted.

Top module: `tlb_hit_buffer`

## Requirements
- R1: After reset, `hit_ready` is 1, `out_valid` is 0 and `ovf_cnt` is 0. A hit is stored on a cycle where `hit_valid` and `hit_ready` are both 1.
- R2: Stamps are binary-reflected Gray codes. The stored ToT is the decoded trailing stamp minus the decoded leading stamp, modulo 2^TS_W (TS_W = 8).
- R3: ToT saturates: any difference of 31 or more is reported as 31, and 30 is reported as 30.
- R4: A trigger sampled on a clock edge where (now − leading stamp) mod 2^TS_W equals LATENCY (100) marks the entry. A marked entry is then presented on `out_row`/`out_tot` with `out_valid` high from the following cycle.
- R5: A trigger at any other age, including LATENCY−1 and LATENCY+1, does not mark the entry, and that hit never appears on the output.
- R6: An unmarked entry stays stored while its age is at most LATENCY. It is released on the edge where its age is LATENCY+1, and `hit_ready` rises after that edge if the buffer was full.
- R7: The buffer holds DEPTH (16) entries. With 16 entries stored, `hit_ready` is 0, and `ovf_cnt` increases by one for every cycle where `hit_valid` is 1 while `hit_ready` is 0.
- R8: Marked entries are read out largest age first, whatever slot they occupy. Entries of equal age are read out lowest slot first, and slots are filled lowest free slot first.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_row` and `out_tot` hold their values. A handshake removes the presented entry.
- R10: Timestamp arithmetic wraps modulo 2^TS_W, so a hit whose stamps and trigger straddle the counter wrap is matched and measured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (bunch-crossing rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit word offered |
| hit_ready | output | 1 | At least one free slot |
| hit_row | input | ROW_W | Row address of the hit |
| hit_le_gray | input | TS_W | Gray leading-edge stamp |
| hit_te_gray | input | TS_W | Gray trailing-edge stamp |
| trig | input | 1 | Trigger pulse, one cycle per trigger |
| ts_gray | input | TS_W | Running Gray timestamp |
| out_valid | output | 1 | Triggered entry presented |
| out_ready | input | 1 | Consumer takes the presented entry |
| out_row | output | ROW_W | Row address of the presented entry |
| out_tot | output | TOT_W | ToT of the presented entry |
| ovf_cnt | output | OVF_W | Refused-hit cycle count (wraps) |

## Verification
A single hit triggered exactly at the latency checks the basic match and ToT path. Triggers one cycle early and one cycle late show that matching uses the exact age, not a window. A fill of all slots followed by idle waiting separates age-out release from readout release, and it also shows the full and refused counting. Pairs of hits written in reverse age order, and pairs of equal age, tell age-ordered readout apart from slot-ordered readout. A set of pulse widths around 31 probes the saturation edge. A hit placed near the counter wrap exposes any arithmetic that does not reduce modulo the stamp width.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      SLOT_FREE   = 2'd0,
      SLOT_WAIT   = 2'd1,
      SLOT_MARKED = 2'd2
   } slot_state_e;
endpackage

// File: rtl/tlb_gray2bin.sv
module tlb_gray2bin #(
   parameter int W = 8
) (
   input  logic [W-1:0] gray_i,
   output logic [W-1:0] bin_o
);
   assign bin_o[W-1] = gray_i[W-1];
   for (genvar b = W - 2; b >= 0; b--) begin : g_bit
      assign bin_o[b] = bin_o[b+1] ^ gray_i[b];
   end
endmodule

// File: rtl/tlb_tot_calc.sv
module tlb_tot_calc #(
   parameter int TS_W  = 8,
   parameter int TOT_W = 5
) (
   input  logic [TS_W-1:0]  le_i,
   input  logic [TS_W-1:0]  te_i,
   output logic [TOT_W-1:0] tot_o
);
   logic [TS_W-1:0] diff;
   assign diff = te_i - le_i;

   if (TOT_W >= TS_W) begin : g_wide
      assign tot_o = TOT_W'(diff);
   end else begin : g_sat
      localparam logic [TS_W-1:0] CAP = TS_W'((1 << TOT_W) - 1);
      assign tot_o = (diff > CAP) ? TOT_W'(CAP) : TOT_W'(diff);
   end
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot
   import tlb_pkg::*;
#(
   parameter int ROW_W   = 8,
   parameter int TS_W    = 8,
   parameter int TOT_W   = 5,
   parameter int LATENCY = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  now_i,
   input  logic             trig_i,
   input  logic             wr_en_i,
   input  logic [ROW_W-1:0] wr_row_i,
   input  logic [TS_W-1:0]  wr_le_i,
   input  logic [TOT_W-1:0] wr_tot_i,
   input  logic             rd_clr_i,
   output slot_state_e      state_o,
   output logic [ROW_W-1:0] row_o,
   output logic [TOT_W-1:0] tot_o,
   output logic [TS_W-1:0]  age_o
);
   localparam logic [TS_W-1:0] LAT = TS_W'(LATENCY);

   slot_state_e      state_q, state_d;
   logic [TS_W-1:0]  le_q;
   logic [ROW_W-1:0] row_q;
   logic [TOT_W-1:0] tot_q;
   logic [TS_W-1:0]  age;

   assign age = now_i - le_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SLOT_FREE:   if (wr_en_i) state_d = SLOT_WAIT;
         SLOT_WAIT: begin
            if (trig_i && (age == LAT)) state_d = SLOT_MARKED;
            else if (age > LAT)         state_d = SLOT_FREE;
         end
         SLOT_MARKED: if (rd_clr_i) state_d = SLOT_FREE;
         default:     state_d = SLOT_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SLOT_FREE;
         le_q    <= '0;
         row_q   <= '0;
         tot_q   <= '0;
      end else begin
         state_q <= state_d;
         if (wr_en_i && (state_q == SLOT_FREE)) begin
            le_q  <= wr_le_i;
            row_q <= wr_row_i;
            tot_q <= wr_tot_i;
         end
      end
   end

   assign state_o = state_q;
   assign row_o   = row_q;
   assign tot_o   = tot_q;
   assign age_o   = age;

   // R4: an exact-age trigger marks a waiting entry
   p_mark_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_WAIT && trig_i && age == LAT) |=> (state_q == SLOT_MARKED));

   // R4: a marked entry is released only by a read handshake
   p_marked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_MARKED && !rd_clr_i) |=> (state_q == SLOT_MARKED));

   // R6: an over-age unmarked entry is released
   p_age_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SLOT_WAIT && age > LAT) |=> (state_q == SLOT_FREE));
endmodule

// File: rtl/tlb_oldest_pick.sv
module tlb_oldest_pick #(
   parameter int DEPTH = 16,
   parameter int TS_W  = 8,
   parameter int IDX_W = 4
) (
   input  logic [DEPTH-1:0]           cand_i,
   input  logic [DEPTH-1:0][TS_W-1:0] age_i,
   output logic                       any_o,
   output logic [IDX_W-1:0]           idx_o
);
   logic [TS_W-1:0] best;

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      best  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cand_i[i] && (!any_o || age_i[i] > best)) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
            best  = age_i[i];
         end
      end
   end
endmodule

// File: rtl/tlb_hit_buffer.sv
module tlb_hit_buffer
   import tlb_pkg::*;
#(
   parameter int ROW_W   = 8,
   parameter int TS_W    = 8,
   parameter int TOT_W   = 5,
   parameter int DEPTH   = 16,
   parameter int LATENCY = 100,
   parameter int OVF_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_valid,
   output logic             hit_ready,
   input  logic [ROW_W-1:0] hit_row,
   input  logic [TS_W-1:0]  hit_le_gray,
   input  logic [TS_W-1:0]  hit_te_gray,
   input  logic             trig,
   input  logic [TS_W-1:0]  ts_gray,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [ROW_W-1:0] out_row,
   output logic [TOT_W-1:0] out_tot,
   output logic [OVF_W-1:0] ovf_cnt
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_chk_depth
      $error("tlb_hit_buffer: DEPTH must be at least 2");
   end
   if (LATENCY < 1 || LATENCY >= (1 << (TS_W - 1))) begin : g_chk_lat
      $error("tlb_hit_buffer: LATENCY must be in 1 .. 2**(TS_W-1)-1");
   end
   if (TOT_W < 1 || ROW_W < 1 || OVF_W < 1) begin : g_chk_w
      $error("tlb_hit_buffer: widths must be positive");
   end

   logic [TS_W-1:0]  now_bin, le_bin, te_bin;
   logic [TOT_W-1:0] new_tot;

   tlb_gray2bin #(.W(TS_W)) u_dec_now (.gray_i(ts_gray),     .bin_o(now_bin));
   tlb_gray2bin #(.W(TS_W)) u_dec_le  (.gray_i(hit_le_gray), .bin_o(le_bin));
   tlb_gray2bin #(.W(TS_W)) u_dec_te  (.gray_i(hit_te_gray), .bin_o(te_bin));

   tlb_tot_calc #(.TS_W(TS_W), .TOT_W(TOT_W)) u_tot (
      .le_i(le_bin), .te_i(te_bin), .tot_o(new_tot));

   slot_state_e                 slot_state [DEPTH];
   logic [ROW_W-1:0]            slot_row   [DEPTH];
   logic [TOT_W-1:0]            slot_tot   [DEPTH];
   logic [DEPTH-1:0][TS_W-1:0]  slot_age;
   logic [DEPTH-1:0]            free_vec, marked_vec;

   logic             accept, pop;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic             any_free;

   always_comb begin
      any_free = 1'b0;
      wr_idx   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (free_vec[i] && !any_free) begin
            any_free = 1'b1;
            wr_idx   = IDX_W'(i);
         end
      end
   end

   assign hit_ready = any_free;
   assign accept    = hit_valid && hit_ready;
   assign pop       = out_valid && out_ready;

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      tlb_slot #(
         .ROW_W(ROW_W), .TS_W(TS_W), .TOT_W(TOT_W), .LATENCY(LATENCY)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .now_i    (now_bin),
         .trig_i   (trig),
         .wr_en_i  (accept && (wr_idx == IDX_W'(s))),
         .wr_row_i (hit_row),
         .wr_le_i  (le_bin),
         .wr_tot_i (new_tot),
         .rd_clr_i (pop && (rd_idx == IDX_W'(s))),
         .state_o  (slot_state[s]),
         .row_o    (slot_row[s]),
         .tot_o    (slot_tot[s]),
         .age_o    (slot_age[s])
      );
      assign free_vec[s]   = (slot_state[s] == SLOT_FREE);
      assign marked_vec[s] = (slot_state[s] == SLOT_MARKED);
   end

   tlb_oldest_pick #(.DEPTH(DEPTH), .TS_W(TS_W), .IDX_W(IDX_W)) u_pick (
      .cand_i (marked_vec),
      .age_i  (slot_age),
      .any_o  (out_valid),
      .idx_o  (rd_idx)
   );

   assign out_row = slot_row[rd_idx];
   assign out_tot = slot_tot[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n)                       ovf_cnt <= '0;
      else if (hit_valid && !hit_ready) ovf_cnt <= ovf_cnt + OVF_W'(1);
   end

   // R7: each refused offer advances the counter by one
   p_ovf_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !hit_ready) |=> (ovf_cnt == $past(ovf_cnt) + OVF_W'(1)));

   // R7: the counter is untouched when nothing is refused
   p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_valid && !hit_ready) |=> $stable(ovf_cnt));

   // R9: a stalled output word holds
   p_out_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_tot)));
endmodule

// File: tb/test_tlb_hit_buffer.sv
`timescale 1ns/1ps
module test_tlb_hit_buffer;
   localparam int LAT = 100;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       hit_valid, hit_ready;
   logic [7:0] hit_row, hit_le_gray, hit_te_gray;
   logic       trig;
   logic [7:0] ts_gray;
   logic       out_valid, out_ready;
   logic [7:0] out_row;
   logic [4:0] out_tot;
   logic [7:0] ovf_cnt;

   int vec_n  = 0;
   int miss_n = 0;
   int tnow   = 0;
   int ovf_exp = 0;

   always #2.5 clk = ~clk;

   tlb_hit_buffer i_tlb_hit_buffer (
      .clk(clk), .rst_n(rst_n),
      .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_row(hit_row),
      .hit_le_gray(hit_le_gray), .hit_te_gray(hit_te_gray),
      .trig(trig), .ts_gray(ts_gray),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_row(out_row), .out_tot(out_tot), .ovf_cnt(ovf_cnt)
   );

   function automatic logic [7:0] gray(int t);
      logic [7:0] b;
      b = t[7:0];
      return b ^ (b >> 1);
   endfunction

   task automatic chk(int act, int exp, string req);
      vec_n++;
      if (act != exp) begin
         miss_n++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock edge; edge sees ts = tnow, then time advances
   task automatic step();
      @(posedge clk);
      #1;
      tnow++;
      ts_gray = gray(tnow);
   endtask

   task automatic wait_until(int t);
      while (tnow < t) step();
   endtask

   task automatic put_hit(int row, int le_t, int te_t);
      hit_valid   = 1'b1;
      hit_row     = row[7:0];
      hit_le_gray = gray(le_t);
      hit_te_gray = gray(te_t);
      step();
      hit_valid   = 1'b0;
   endtask

   task automatic fire();
      trig = 1'b1;
      step();
      trig = 1'b0;
   endtask

   task automatic pop(int row, int tot, string req);
      chk(int'(out_valid), 1, req);
      chk(int'(out_row), row, req);
      chk(int'(out_tot), tot, req);
      out_ready = 1'b1;
      step();
      out_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk(int'(hit_ready), 1, "R1 ready after reset");
      chk(int'(out_valid), 0, "R1 out_valid after reset");
      chk(int'(ovf_cnt), 0, "R1 ovf after reset");
   endtask

   task automatic t_basic();
      int s = tnow;
      put_hit(8'h05, s, s + 7);
      wait_until(s + LAT);
      fire();
      pop(8'h05, 7, "R4/R2 exact trigger");
      chk(int'(out_valid), 0, "R4 drained");
   endtask

   task automatic t_saturate();
      int s = tnow;
      put_hit(8'h0A, s,     s + 30);
      put_hit(8'h0B, s + 1, s + 1 + 31);
      put_hit(8'h0C, s + 2, s + 2 + 32);
      put_hit(8'h0D, s + 3, s + 3 + 200);
      wait_until(s + LAT);
      fire(); fire(); fire(); fire();
      pop(8'h0A, 30, "R3 width 30");
      pop(8'h0B, 31, "R3 width 31");
      pop(8'h0C, 31, "R3 width 32");
      pop(8'h0D, 31, "R3 width 200");
   endtask

   task automatic t_mismatch();
      int s = tnow;
      put_hit(8'h21, s, s + 4);
      wait_until(s + LAT - 1);
      fire();
      chk(int'(out_valid), 0, "R5 early trigger ignored");
      step();
      fire();
      chk(int'(out_valid), 0, "R5 late trigger ignored");
      wait_until(s + LAT + 5);
      chk(int'(out_valid), 0, "R5 never read");
   endtask

   task automatic t_fill_age();
      int s = tnow;
      for (int k = 0; k < 16; k++) put_hit(k + 8'h40, tnow, tnow + 3);
      chk(int'(hit_ready), 0, "R7 full after 16");
      hit_valid = 1'b1;
      step(); step(); step();
      hit_valid = 1'b0;
      ovf_exp += 3;
      chk(int'(ovf_cnt), ovf_exp, "R7 refused cycles counted");
      wait_until(s + LAT + 1);
      chk(int'(hit_ready), 0, "R6 kept at age LATENCY");
      step();
      chk(int'(hit_ready), 1, "R6 released at LATENCY+1");
      wait_until(s + 15 + LAT + 3);
      chk(int'(out_valid), 0, "R6 aged entries not read");
      chk(int'(ovf_cnt), ovf_exp, "R7 no refusal while idle");
   endtask

   task automatic t_order();
      int s = tnow;
      int u;
      put_hit(8'h22, s, s + 2);         // younger, lower slot
      put_hit(8'h11, s - 1, s + 3);     // older, higher slot
      wait_until(s + LAT - 1);
      fire(); fire();
      chk(int'(out_row), 8'h11, "R8 oldest first");
      step(); step();
      chk(int'(out_valid), 1, "R9 valid held in stall");
      chk(int'(out_row), 8'h11, "R9 row held in stall");
      chk(int'(out_tot), 4, "R9 tot held in stall");
      pop(8'h11, 4, "R8 first pop");
      pop(8'h22, 2, "R8 second pop");
      chk(int'(out_valid), 0, "R9 drained");
      u = tnow;
      put_hit(8'h33, u, u + 5);
      put_hit(8'h44, u, u + 9);
      wait_until(u + LAT);
      fire();
      pop(8'h33, 5, "R8 tie lowest slot");
      pop(8'h44, 9, "R8 tie second");
   endtask

   task automatic t_wrap();
      int s;
      while ((tnow % 256) != 250) step();
      s = tnow;
      put_hit(8'h5A, s, s + 9);
      wait_until(s + LAT);
      fire();
      pop(8'h5A, 9, "R10 across wrap");
   endtask

   initial begin
      #(200000 * 5);
      miss_n++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
      $finish;
   end

   initial begin
      rst_n = 1'b0; hit_valid = 1'b0; hit_row = '0;
      hit_le_gray = '0; hit_te_gray = '0; trig = 1'b0;
      out_ready = 1'b0; ts_gray = gray(0);
      step(); step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic();
      t_saturate();
      t_mismatch();
      t_fill_age();
      t_order();
      t_wrap();
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
      $finish;
   end
endmodule